// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block carries data between an A side and a B side through two separate storage banks. One bank serves traffic from A to B and the other serves traffic from B to A. Each direction has three active-low controls: a chip-enable, a latch-enable and an output-enable. The chip-enable gates both the entry of data into the bank and the driving of its output. While the chip-enable and latch-enable of a direction are both low, that bank is transparent, and its output follows the input port within the same cycle. When the bank leaves transparency, it keeps the last value it sampled.

The pads are modelled as separate vectors for input, output and per-bit output-enable, so that a pad wrapper can build the real three-state pins. The datapath is divided into `NUM_HALVES` equal slices of `HALF_W` bits. Each slice has its own full set of six controls. The block can therefore run as independent narrow transceivers, or as one wide transceiver when all slices get the same controls.

The latch is modelled in the clock domain. A bank loads its input on every clock edge at which it is transparent. A floating output reads as zero on its data vector. The house style calls for a valid/ready interface, but it does not fit here: this block has only level controls, so every pin is a plain signal.

Top module: `dual_latch_xcvr`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), every stored value in both directions is zero. A direction that is enabled with its latch-enable high then drives zero.
- R2: While ce_n, le_n and oe_n of a direction are all low, the output bits of that slice equal the input bits of the same slice in the same cycle.
- R3: When le_n rises while ce_n stays low, the bank keeps the input value sampled at the last clock edge where it was transparent. Later input changes do not alter the output while le_n stays high.
- R4: When ce_n rises while le_n is low, transparency also ends. When ce_n returns low with le_n high, the output shows the value captured before ce_n rose.
- R5: While ce_n is high, the bank holds its value whatever le_n and the input do, and its output floats whatever oe_n is.
- R6: The output-enable bits of a slice are all ones exactly when ce_n and oe_n of that direction are both low. Otherwise they are all zeros and the matching data bits read zero.
- R7: Slice h uses bits [h*HALF_W +: HALF_W]. Controls for one slice never change the stored value or the output of another slice.
- R8: The B-to-A direction mirrors A-to-B with its own controls. Storage in one direction is not disturbed by activity in the other.
- R9: While a direction is enabled with le_n high, its output shows the stored value and not the live input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which transparent banks sample |
| rst_n | input | 1 | Asynchronous active-low reset of stored values |
| a_in | input | NUM_HALVES*HALF_W | Value seen on the A side pins |
| a_out | output | NUM_HALVES*HALF_W | Value driven onto the A side (B-to-A data) |
| a_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for the A side |
| b_in | input | NUM_HALVES*HALF_W | Value seen on the B side pins |
| b_out | output | NUM_HALVES*HALF_W | Value driven onto the B side (A-to-B data) |
| b_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for the B side |
| ab_ce_n | input | NUM_HALVES | A-to-B chip-enable per slice, active low |
| ab_le_n | input | NUM_HALVES | A-to-B latch-enable per slice, active low |
| ab_oe_n | input | NUM_HALVES | A-to-B output-enable per slice, active low |
| ba_ce_n | input | NUM_HALVES | B-to-A chip-enable per slice, active low |
| ba_le_n | input | NUM_HALVES | B-to-A latch-enable per slice, active low |
| ba_oe_n | input | NUM_HALVES | B-to-A output-enable per slice, active low |

## Verification
The assertions assume that the controls and data change only between clock edges. They also assume that data is held steady across the edge at which latch-enable or chip-enable rises, which is the clock-domain form of setup and hold. The bench changes every input on the falling clock edge and samples halfway before the next rising edge. It always changes the data in the same step that closes a bank, never before, so the captured value is the one present at the last transparent edge.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xfer_latch.sv
module xfer_latch
  import dlx_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctrl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_en
);
  logic         transp;
  logic         drive;
  logic [W-1:0] store_q;
  logic [W-1:0] latch_val;

  assign transp = !ctl.ce_n && !ctl.le_n;
  assign drive  = !ctl.ce_n && !ctl.oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_q <= '0;
    else if (transp) store_q <= din;
  end

  assign latch_val = transp ? din : store_q;
  assign dout      = drive ? latch_val : '0;
  assign dout_en   = {W{drive}};

  // R3 R4 R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce_n || ctl.le_n) |=> $stable(store_q));

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ce_n && !ctl.le_n) |=> (store_q == $past(din)));

  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ce_n && !ctl.le_n && !ctl.oe_n) |-> (dout == din));

  // R9
  show_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.ce_n && ctl.le_n && !ctl.oe_n) |-> (dout == store_q));

  // R5
  float_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ce_n |-> (dout_en == '0));
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import dlx_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctrl_t    ab_ctl,
  input  dir_ctrl_t    ba_ctl,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  xfer_latch #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl),
    .din(a_in), .dout(b_out), .dout_en(b_oe)
  );

  xfer_latch #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl),
    .din(b_in), .dout(a_out), .dout_en(a_oe)
  );
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import dlx_pkg::*;
#(
  parameter int HALF_W     = 18,
  parameter int NUM_HALVES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_HALVES*HALF_W-1:0]   a_in,
  output logic [NUM_HALVES*HALF_W-1:0]   a_out,
  output logic [NUM_HALVES*HALF_W-1:0]   a_oe,
  input  logic [NUM_HALVES*HALF_W-1:0]   b_in,
  output logic [NUM_HALVES*HALF_W-1:0]   b_out,
  output logic [NUM_HALVES*HALF_W-1:0]   b_oe,
  input  logic [NUM_HALVES-1:0]          ab_ce_n,
  input  logic [NUM_HALVES-1:0]          ab_le_n,
  input  logic [NUM_HALVES-1:0]          ab_oe_n,
  input  logic [NUM_HALVES-1:0]          ba_ce_n,
  input  logic [NUM_HALVES-1:0]          ba_le_n,
  input  logic [NUM_HALVES-1:0]          ba_oe_n
);
  localparam int TOT_W = NUM_HALVES * HALF_W;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dir_ctrl_t ab_ctl, ba_ctl;
    assign ab_ctl = '{ce_n: ab_ce_n[h], le_n: ab_le_n[h], oe_n: ab_oe_n[h]};
    assign ba_ctl = '{ce_n: ba_ce_n[h], le_n: ba_le_n[h], oe_n: ba_oe_n[h]};

    xcvr_half #(.W(HALF_W)) u_half (
      .clk(clk), .rst_n(rst_n),
      .ab_ctl(ab_ctl), .ba_ctl(ba_ctl),
      .a_in(a_in[h*HALF_W +: HALF_W]),
      .a_out(a_out[h*HALF_W +: HALF_W]),
      .a_oe(a_oe[h*HALF_W +: HALF_W]),
      .b_in(b_in[h*HALF_W +: HALF_W]),
      .b_out(b_out[h*HALF_W +: HALF_W]),
      .b_oe(b_oe[h*HALF_W +: HALF_W])
    );
  end

  // R6
  float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((a_out & ~a_oe) == TOT_W'(0)) && ((b_out & ~b_oe) == TOT_W'(0))));
endmodule

// File: tb/sim_dual_latch_xcvr.sv
module sim_dual_latch_xcvr;
  localparam int W  = 18;
  localparam int NH = 2;
  localparam int T  = NH * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [T-1:0] a_in = '0, b_in = '0;
  logic [T-1:0] a_out, a_oe, b_out, b_oe;
  logic [NH-1:0] ab_ce_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NH-1:0] ba_ce_n = '1, ba_le_n = '1, ba_oe_n = '1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dual_latch_xcvr #(.HALF_W(W), .NUM_HALVES(NH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  // ce, le, oe, din, expected enable, expected output (slice 0, A to B)
  localparam logic [39:0] VEC [0:9] = '{
    {3'b000, 18'h01234, 1'b1, 18'h01234},  // R2
    {3'b000, 18'h00abc, 1'b1, 18'h00abc},  // R2
    {3'b010, 18'h3ffff, 1'b1, 18'h00abc},  // R3 R9
    {3'b011, 18'h00005, 1'b0, 18'h00000},  // R6
    {3'b100, 18'h00007, 1'b0, 18'h00000},  // R5
    {3'b010, 18'h00007, 1'b1, 18'h00abc},  // R5
    {3'b000, 18'h02222, 1'b1, 18'h02222},  // R2
    {3'b100, 18'h02222, 1'b0, 18'h00000},  // R4
    {3'b100, 18'h01111, 1'b0, 18'h00000},  // R4 R5
    {3'b010, 18'h01111, 1'b1, 18'h02222}   // R4
  };

  task automatic chk(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset clears both directions
    @(negedge clk);
    ab_ce_n = '0; ab_oe_n = '0; ba_ce_n = '0; ba_oe_n = '0;
    a_in = '1; b_in = '1;
    #5;
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 b_oe", b_oe, '1);
    ba_ce_n = '1; ab_ce_n = '1; a_in = '0; b_in = '0;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {ab_ce_n[0], ab_le_n[0], ab_oe_n[0]} = VEC[i][39:37];
      a_in[W-1:0] = VEC[i][36:19];
      #5;
      chk($sformatf("R2-R6 vec%0d out", i), T'(b_out[W-1:0]), T'(VEC[i][17:0]));
      chk($sformatf("R6 vec%0d oe", i), T'(b_oe[W-1:0]), T'({W{VEC[i][18]}}));
    end

    // R7: slice 1 loads while slice 0 holds 0x2222
    @(negedge clk);
    ab_ce_n[1] = 1'b0; ab_le_n[1] = 1'b0; ab_oe_n[1] = 1'b0;
    a_in = {18'h3c3c3, 18'h15555};
    #5;
    chk("R7 slice1 pass", T'(b_out[T-1:W]), T'(18'h3c3c3));
    chk("R7 slice0 held", T'(b_out[W-1:0]), T'(18'h02222));
    @(negedge clk);
    ab_le_n[1] = 1'b1;
    a_in = '0;
    #5;
    chk("R7 slice1 hold", T'(b_out[T-1:W]), T'(18'h3c3c3));
    chk("R7 slice0 unchanged", T'(b_out[W-1:0]), T'(18'h02222));

    // R8: B-to-A on slice 0 while A-to-B holds
    @(negedge clk);
    ba_ce_n[0] = 1'b0; ba_le_n[0] = 1'b0; ba_oe_n[0] = 1'b0;
    b_in[W-1:0] = 18'h0f0f0;
    #5;
    chk("R8 b2a pass", T'(a_out[W-1:0]), T'(18'h0f0f0));
    chk("R8 b2a oe", T'(a_oe[W-1:0]), T'({W{1'b1}}));
    chk("R8 a2b undisturbed", T'(b_out[W-1:0]), T'(18'h02222));
    @(negedge clk);
    ba_le_n[0] = 1'b1;
    b_in[W-1:0] = 18'h2aaaa;
    #5;
    chk("R8 b2a hold", T'(a_out[W-1:0]), T'(18'h0f0f0));
    chk("R8 slice1 b2a float", T'(a_oe[T-1:W]), '0);
    chk("R8 a2b still", b_out, {18'h3c3c3, 18'h02222});

    finish_run();
  end
endmodule